// File: doc/BRIEF.md
# Bit-Sliced Lookup-Table Datapath with Programmable Carry Chains

This block evaluates a small dataflow graph of integer operations on up to four
32-bit operands in a single pass. Every bit position is an identical slice. Each
slice looks up the bit of all four operands in small truth tables that the user
loads. The tables give, per bit, a propagate and a generate signal. A ripple
carry generator turns those into a carry vector. A second pair of tables sees the
first carry as well and feeds a second carry generator, so two dependent
additions or subtractions fit in one pass. A final pair of output tables combines
the operand bits with both carries into two 32-bit results.

Because adders are split into programmable propagate/generate tables and a shared
carry network, any mix of bitwise logic and add/subtract becomes table contents
rather than fixed ALUs. An addition uses propagate = A xor B, generate = A and B,
and a sum bit equal to propagate xor carry-in. A subtraction uses the inverted
second operand with the chain's bit-0 carry seed set to 1. The operand path is
combinational, and the two results are registered once at the output.

Top module: `lutcarry_fu`

## Requirements
- R1: A synchronous reset clears both results to zero and clears every table and both carry seeds, so the results stay zero for any operands until tables are loaded.
- R2: Each result is due at the first rising clock edge after its operands are applied, and it holds the previous value until that edge.
- R3: A write with `cfg_we` high stores `cfg_data` at the clock edge, into the target picked by `cfg_sel`: 0 first-stage propagate table (data[15:0]), 1 first-stage generate table (data[15:0]), 2 second-stage propagate table (data[31:0]), 3 second-stage generate table (data[31:0]), 4 table of result 0 (data[63:0]), 5 table of result 1 (data[63:0]), 6 carry seeds (data[0] seeds chain 1, data[1] seeds chain 2).
- R4: With `cfg_we` low, or with `cfg_sel` equal to 7, no table and no seed changes.
- R5: The first-stage tables of bit i are indexed by {in4[i], in3[i], in2[i], in1[i]} (in1 the least significant index bit). Chain-1 carry into bit 0 is its seed, and the carry into bit i is g1[i-1] or (p1[i-1] and carry into bit i-1).
- R6: The second-stage tables of bit i are indexed by {c1[i], in4[i], in3[i], in2[i], in1[i]}, with c1[i] the chain-1 carry into bit i. Chain 2 follows the same ripple rule with its own seed.
- R7: Each result table of bit i is indexed by {c2[i], c1[i], in4[i], in3[i], in2[i], in1[i]}. The two results use separate tables and are computed at the same time.
- R8: The carry out of bit 31 is dropped, so sums wrap modulo 2^32.
- R9: With all tables set to bitwise functions, the unit gives pure logic. An example is (in1 xor in2) or (in3 and in4), which matches its 16-row truth table exactly.
- R10: Subtraction in1 - in2 on chain 1 and in3 - in4 on chain 2, each using an inverted operand and a seed of 1, are both correct in the same pass.
- R11: Two dependent additions run in one pass: result 0 equals in1 + in2 + in3 while result 1 equals in1 + in2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 3 | Write target (encoding in R3) |
| cfg_data | input | 64 | Table contents to write |
| in1 | input | 32 | Operand 1 |
| in2 | input | 32 | Operand 2 |
| in3 | input | 32 | Operand 3 |
| in4 | input | 32 | Operand 4 |
| res0 | output | 32 | Result 0, registered |
| res1 | output | 32 | Result 1, registered |

## Verification
A result is due one rising edge after its operands are driven. A table write takes effect at its own edge, so the first result that uses the new tables appears one edge later. The bench changes inputs on the falling edge and reads the results at the next falling edge, half a cycle after the edge that registered them. For the latency case it also reads the results shortly after driving new operands, before any edge, and expects the old values there.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
    localparam int NOPS = 4;
    localparam int T1   = 1 << NOPS;
    localparam int T2   = 1 << (NOPS + 1);
    localparam int T3   = 1 << (NOPS + 2);

    typedef enum logic [2:0] {
        SEL_P1   = 3'd0,
        SEL_G1   = 3'd1,
        SEL_P2   = 3'd2,
        SEL_G2   = 3'd3,
        SEL_O0   = 3'd4,
        SEL_O1   = 3'd5,
        SEL_SEED = 3'd6,
        SEL_NONE = 3'd7
    } sel_e;

    typedef struct packed {
        logic [T1-1:0] p1;
        logic [T1-1:0] g1;
        logic [T2-1:0] p2;
        logic [T2-1:0] g2;
        logic [T3-1:0] o0;
        logic [T3-1:0] o1;
        logic          seed1;
        logic          seed2;
    } cfg_t;
endpackage

// File: rtl/lcf_cfg_store.sv
module lcf_cfg_store
    import lcf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    sel,
    input  logic [T3-1:0] data,
    output cfg_t          cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel_e'(sel))
                SEL_P1:   cfg_d.p1 = data[T1-1:0];
                SEL_G1:   cfg_d.g1 = data[T1-1:0];
                SEL_P2:   cfg_d.p2 = data[T2-1:0];
                SEL_G2:   cfg_d.g2 = data[T2-1:0];
                SEL_O0:   cfg_d.o0 = data;
                SEL_O1:   cfg_d.o1 = data;
                SEL_SEED: begin
                    cfg_d.seed1 = data[0];
                    cfg_d.seed2 = data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/lcf_bit_lut.sv
module lcf_bit_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] lut_bits,
    input  logic [K-1:0]      idx,
    output logic              bit_o
);
    assign bit_o = lut_bits[idx];
endmodule

// File: rtl/lcf_carry_chain.sv
module lcf_carry_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic         seed,
    output logic [W-1:0] carry_in
);
    logic ripple;

    always_comb begin
        ripple = seed;
        for (int i = 0; i < W; i++) begin
            carry_in[i] = ripple;
            ripple      = gen[i] | (prop[i] & ripple);
        end
    end
endmodule

// File: rtl/lutcarry_fu.sv
module lutcarry_fu
    import lcf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [T3-1:0] cfg_data,
    input  logic [W-1:0]  in1,
    input  logic [W-1:0]  in2,
    input  logic [W-1:0]  in3,
    input  logic [W-1:0]  in4,
    output logic [W-1:0]  res0,
    output logic [W-1:0]  res1
);
    typedef struct packed {
        logic [W-1:0] r0;
        logic [W-1:0] r1;
    } out_t;

    cfg_t         cfg_q;
    logic [W-1:0] p1v, g1v, c1v;
    logic [W-1:0] p2v, g2v, c2v;
    logic [W-1:0] o0v, o1v;
    out_t         out_d, out_q;

    lcf_cfg_store u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .sel  (cfg_sel),
        .data (cfg_data),
        .cfg  (cfg_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic [NOPS-1:0] ob;
        assign ob = {in4[i], in3[i], in2[i], in1[i]};

        lcf_bit_lut #(.K(NOPS)) u_p1 (.lut_bits(cfg_q.p1), .idx(ob), .bit_o(p1v[i]));
        lcf_bit_lut #(.K(NOPS)) u_g1 (.lut_bits(cfg_q.g1), .idx(ob), .bit_o(g1v[i]));

        lcf_bit_lut #(.K(NOPS+1)) u_p2 (.lut_bits(cfg_q.p2), .idx({c1v[i], ob}), .bit_o(p2v[i]));
        lcf_bit_lut #(.K(NOPS+1)) u_g2 (.lut_bits(cfg_q.g2), .idx({c1v[i], ob}), .bit_o(g2v[i]));

        lcf_bit_lut #(.K(NOPS+2)) u_o0 (.lut_bits(cfg_q.o0), .idx({c2v[i], c1v[i], ob}), .bit_o(o0v[i]));
        lcf_bit_lut #(.K(NOPS+2)) u_o1 (.lut_bits(cfg_q.o1), .idx({c2v[i], c1v[i], ob}), .bit_o(o1v[i]));
    end

    lcf_carry_chain #(.W(W)) u_chain1 (
        .prop     (p1v),
        .gen      (g1v),
        .seed     (cfg_q.seed1),
        .carry_in (c1v)
    );

    lcf_carry_chain #(.W(W)) u_chain2 (
        .prop     (p2v),
        .gen      (g2v),
        .seed     (cfg_q.seed2),
        .carry_in (c2v)
    );

    always_comb begin
        out_d    = out_q;
        out_d.r0 = o0v;
        out_d.r1 = o1v;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign res0 = out_q.r0;
    assign res1 = out_q.r1;
endmodule

// File: rtl/lcf_checker.sv
module lcf_checker
    import lcf_pkg::*;
#(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [2:0]    cfg_sel,
    input logic [T3-1:0] cfg_data,
    input logic [W-1:0]  in1,
    input logic [W-1:0]  in2,
    input logic [W-1:0]  in3,
    input logic [W-1:0]  in4,
    input logic [W-1:0]  res0,
    input logic [W-1:0]  res1,
    input cfg_t          cfg
);
    // R1: reset leaves results and tables at zero
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (res0 == '0 && res1 == '0 && cfg == '0));

    // R4: no write enable, no table change
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg));

    // R4: select 7 is an empty target
    p_badsel_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 3'd7) |=> $stable(cfg));

    // R3: first-stage propagate table takes the low data bits
    p_p1_write_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 3'd0) |=> cfg.p1 == $past(cfg_data[T1-1:0]));

    // R3: seed write places bit 0 and bit 1
    p_seed_write_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 3'd6) |=> {cfg.seed2, cfg.seed1} == $past(cfg_data[1:0]));

    // R2: steady operands and tables give steady results one edge later
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(in1) && $stable(in2) && $stable(in3) &&
         $stable(in4) && $stable(cfg)) |=> ($stable(res0) && $stable(res1)));
endmodule

bind lutcarry_fu lcf_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .in1      (in1),
    .in2      (in2),
    .in3      (in3),
    .in4      (in4),
    .res0     (res0),
    .res1     (res1),
    .cfg      (cfg_q)
);

// File: tb/lutcarry_fu_bench.sv
`timescale 1ns/1ps
module lutcarry_fu_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [63:0]   cfg_data = '0;
    logic [W-1:0]  in1 = '0, in2 = '0, in3 = '0, in4 = '0;
    logic [W-1:0]  res0, res1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    lutcarry_fu #(.W(W)) u_lutcarry_fu (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .in1(in1), .in2(in2), .in3(in3), .in4(in4), .res0(res0), .res1(res1)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [63:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_all(input logic [15:0] p1, input logic [15:0] g1,
                            input logic [31:0] p2, input logic [31:0] g2,
                            input logic [63:0] o0, input logic [63:0] o1,
                            input logic [1:0] seeds);
        wr(3'd0, {48'h0, p1});
        wr(3'd1, {48'h0, g1});
        wr(3'd2, {32'h0, p2});
        wr(3'd3, {32'h0, g2});
        wr(3'd4, o0);
        wr(3'd5, o1);
        wr(3'd6, {62'h0, seeds});
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic [W-1:0] d);
        @(negedge clk);
        in1 = a; in2 = b; in3 = c; in4 = d;
        @(negedge clk);
    endtask

    // R1: reset state and cleared tables
    task automatic t_reset();
        check("R1 res0 in reset", res0, '0);
        check("R1 res1 in reset", res1, '0);
        @(negedge clk);
        rst = 1'b0;
        apply(32'hDEAD_BEEF, 32'h0123_4567, 32'hFFFF_FFFF, 32'h89AB_CDEF);
        check("R1 res0 cleared tables", res0, '0);
        check("R1 res1 cleared tables", res1, '0);
    endtask

    // R3 R5 R7: add on chain 1, xor on result 1
    task automatic t_add();
        logic [15:0] p, g;
        logic [63:0] o0, o1;
        for (int k = 0; k < 64; k++) begin
            logic [5:0] x;
            x = 6'(k);
            o0[k] = x[0] ^ x[1] ^ x[4];
            o1[k] = x[2] ^ x[3];
            if (k < 16) begin
                p[k] = x[0] ^ x[1];
                g[k] = x[0] & x[1];
            end
        end
        load_all(p, g, '0, '0, o0, o1, 2'b00);
        for (int n = 0; n < 8; n++) begin
            logic [31:0] a, b, c, d;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
            lfsr = next_rand(lfsr); c = lfsr;
            lfsr = next_rand(lfsr); d = lfsr;
            apply(a, b, c, d);
            check("R5 R7 sum in1+in2", res0, a + b);
            check("R7 res1 in3^in4", res1, c ^ d);
        end
    endtask

    // R8: wraparound, table from t_add still loaded
    task automatic t_wrap();
        apply(32'hFFFF_FFFF, 32'h0000_0001, '0, '0);
        check("R8 all-ones plus one", res0, 32'h0);
        apply(32'h8000_0000, 32'h8000_0000, '0, '0);
        check("R8 top bit carry dropped", res0, 32'h0);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, '0);
        check("R8 max plus max", res0, 32'hFFFF_FFFE);
    endtask

    // R2: result appears only after the next rising edge
    task automatic t_latency();
        apply(32'd10, 32'd20, '0, '0);
        check("R2 first value", res0, 32'd30);
        @(negedge clk);
        in1 = 32'd100; in2 = 32'd5;
        #1;
        check("R2 old value before edge", res0, 32'd30);
        @(negedge clk);
        check("R2 new value after edge", res0, 32'd105);
    endtask

    // R4: writes with enable low or select 7 leave the adder intact
    task automatic t_ignore();
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 3'd0; cfg_data = '1;
        @(negedge clk);
        cfg_sel = 3'd6;
        @(negedge clk);
        cfg_sel = 3'd4;
        @(negedge clk);
        wr(3'd7, '1);
        apply(32'h0000_1111, 32'h0000_2222, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        check("R4 add unchanged", res0, 32'h0000_3333);
        check("R4 res1 unchanged", res1, 32'hFFFF_FFFF);
        apply(32'hFFFF_FFFF, 32'h0000_0001, '0, '0);
        check("R4 seed unchanged", res0, 32'h0);
    endtask

    // R9: pure logic
    task automatic t_logic();
        logic [63:0] o0, o1;
        for (int k = 0; k < 64; k++) begin
            logic [5:0] x;
            x = 6'(k);
            o0[k] = (x[0] ^ x[1]) | (x[2] & x[3]);
            o1[k] = ~(x[0] & x[3]);
        end
        load_all('0, '0, '0, '0, o0, o1, 2'b00);
        for (int r = 0; r < 16; r++) begin
            logic [3:0] v;
            v = 4'(r);
            apply({32{v[0]}}, {32{v[1]}}, {32{v[2]}}, {32{v[3]}});
            check("R9 truth table row", res0, {32{(v[0] ^ v[1]) | (v[2] & v[3])}});
        end
        for (int n = 0; n < 4; n++) begin
            logic [31:0] a, b, c, d;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
            lfsr = next_rand(lfsr); c = lfsr;
            lfsr = next_rand(lfsr); d = lfsr;
            apply(a, b, c, d);
            check("R9 mixed logic res0", res0, (a ^ b) | (c & d));
            check("R9 mixed logic res1", res1, ~(a & d));
        end
    endtask

    // R10 R6: two independent subtractions with seeds set
    task automatic t_sub();
        logic [15:0] p, g;
        logic [31:0] p2, g2;
        logic [63:0] o0, o1;
        for (int k = 0; k < 64; k++) begin
            logic [5:0] x;
            x = 6'(k);
            o0[k] = x[0] ^ ~x[1] ^ x[4];
            o1[k] = x[2] ^ ~x[3] ^ x[5];
            if (k < 32) begin
                p2[k] = x[2] ^ ~x[3];
                g2[k] = x[2] & ~x[3];
            end
            if (k < 16) begin
                p[k] = x[0] ^ ~x[1];
                g[k] = x[0] & ~x[1];
            end
        end
        load_all(p, g, p2, g2, o0, o1, 2'b11);
        apply(32'd5, 32'd7, 32'd0, 32'd1);
        check("R10 5-7", res0, 32'hFFFF_FFFE);
        check("R10 0-1", res1, 32'hFFFF_FFFF);
        for (int n = 0; n < 6; n++) begin
            logic [31:0] a, b, c, d;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
            lfsr = next_rand(lfsr); c = lfsr;
            lfsr = next_rand(lfsr); d = lfsr;
            apply(a, b, c, d);
            check("R10 in1-in2", res0, a - b);
            check("R10 R6 in3-in4", res1, c - d);
        end
    endtask

    // R11 R6 R7: dependent additions through both chains
    task automatic t_chain();
        logic [15:0] p, g;
        logic [31:0] p2, g2;
        logic [63:0] o0, o1;
        for (int k = 0; k < 64; k++) begin
            logic [5:0] x;
            logic s;
            x = 6'(k);
            s = x[0] ^ x[1] ^ x[4];
            o0[k] = s ^ x[2] ^ x[5];
            o1[k] = s;
            if (k < 32) begin
                p2[k] = s ^ x[2];
                g2[k] = s & x[2];
            end
            if (k < 16) begin
                p[k] = x[0] ^ x[1];
                g[k] = x[0] & x[1];
            end
        end
        load_all(p, g, p2, g2, o0, o1, 2'b00);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, '0);
        check("R11 carry across stages", res0, 32'h0000_0001);
        for (int n = 0; n < 6; n++) begin
            logic [31:0] a, b, c, d;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
            lfsr = next_rand(lfsr); c = lfsr;
            lfsr = next_rand(lfsr); d = lfsr;
            apply(a, b, c, d);
            check("R11 in1+in2+in3", res0, a + b + c);
            check("R11 R7 in1+in2", res1, a + b);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_add();
        t_wrap();
        t_latency();
        t_ignore();
        t_logic();
        t_sub();
        t_chain();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule